// File: doc/BRIEF.md
# Universal Shift Register

This block is a parameterised register, four bits wide by default. On every rising clock edge it does one of four things: it keeps its contents, shifts them one place toward the low end, shifts them one place toward the high end, or loads a parallel word. A synchronous clear overrides the mode and zeroes every bit. It can serve as a parallel-to-serial or serial-to-parallel converter, as a delay line for serial samples, or as one stage of a longer register made by chaining several instances.

Each bit is a small cell. The cell picks its next value from itself, from its neighbour on the left, from its neighbour on the right, from its parallel input, or from a constant zero, and stores that value in a flip-flop. The bit at each end takes a serial input pin in place of the missing neighbour. Both end bits also drive output pins, so the serial output of one instance can feed the serial input of the next. Bit `WIDTH-1` is the leftmost bit and bit 0 is the rightmost.

The selection inputs form a plain control word. There is no handshake. `WIDTH` must be at least 2.

Top module: `usr_shift`

## Requirements
- R1: When `clr` is 1 at a rising edge, every bit of `q` is 0 after that edge, whatever the values of `mode`, `din` and the serial inputs.
- R2: With `clr` at 0 and `mode` = 2'b00 (hold), `q` is unchanged by the edge.
- R3: With `clr` at 0 and `mode` = 2'b01 (shift right), each bit `q[i]` takes the old `q[i+1]`, and `q[WIDTH-1]` takes `shr_in`.
- R4: With `clr` at 0 and `mode` = 2'b10 (shift left), each bit `q[i]` takes the old `q[i-1]`, and `q[0]` takes `shl_in`.
- R5: With `clr` at 0 and `mode` = 2'b11 (load), `q` takes `din`.
- R6: `msb_out` always equals `q[WIDTH-1]` and `lsb_out` always equals `q[0]`. On a right shift, `lsb_out` therefore carries the bit that was second from the right, and on a left shift `msb_out` carries the bit that was second from the left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all cells |
| clr | input | 1 | Synchronous clear; overrides `mode` |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| din | input | WIDTH | Parallel load word |
| shr_in | input | 1 | Serial bit that enters at the left end on a right shift |
| shl_in | input | 1 | Serial bit that enters at the right end on a left shift |
| q | output | WIDTH | Register contents |
| msb_out | output | 1 | Leftmost bit, for chaining |
| lsb_out | output | 1 | Rightmost bit, for chaining |

## Verification
The assertions assume that `clr`, `mode`, `din` and both serial inputs hold known values at every rising edge. They also assume that the first meaningful edge is a clear, because before that the contents are unknown and the checker stays disarmed. The stimulus opens with a clear and then changes inputs only on falling edges, always to defined values. After a set of directed sequences it draws random modes and data, and it asserts clear together with each of the four mode values.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    SRC_SELF,
    SRC_LEFT,
    SRC_RIGHT,
    SRC_PAR,
    SRC_ZERO
  } src_e;
endpackage

// File: rtl/usr_ctl.sv
module usr_ctl
  import usr_pkg::*;
(
  input  logic       clr,
  input  logic [1:0] mode,
  output src_e       src
);
  always_comb begin
    if (clr) begin
      src = SRC_ZERO;
    end else begin
      unique case (mode_e'(mode))
        MODE_HOLD: src = SRC_SELF;
        MODE_SHR:  src = SRC_LEFT;
        MODE_SHL:  src = SRC_RIGHT;
        MODE_LOAD: src = SRC_PAR;
        default:   src = SRC_SELF;
      endcase
    end
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic clk,
  input  src_e src,
  input  logic from_left,
  input  logic from_right,
  input  logic par,
  output logic q
);
  logic nxt;

  always_comb begin
    unique case (src)
      SRC_SELF:  nxt = q;
      SRC_LEFT:  nxt = from_left;
      SRC_RIGHT: nxt = from_right;
      SRC_PAR:   nxt = par;
      SRC_ZERO:  nxt = 1'b0;
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    q <= nxt;
  end
endmodule

// File: rtl/usr_shift.sv
module usr_shift
  import usr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] din,
  input  logic             shr_in,
  input  logic             shl_in,
  output logic [WIDTH-1:0] q,
  output logic             msb_out,
  output logic             lsb_out
);
  localparam int MSB = WIDTH - 1;

  src_e             src;
  logic [WIDTH-1:0] lft;
  logic [WIDTH-1:0] rgt;
  logic [WIDTH-1:0] cells;

  usr_ctl u_ctl (
    .clr  (clr),
    .mode (mode),
    .src  (src)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign lft[i] = shr_in;
    end else begin : g_mid_l
      assign lft[i] = cells[i+1];
    end

    if (i == 0) begin : g_bot
      assign rgt[i] = shl_in;
    end else begin : g_mid_r
      assign rgt[i] = cells[i-1];
    end

    usr_cell u_cell (
      .clk        (clk),
      .src        (src),
      .from_left  (lft[i]),
      .from_right (rgt[i]),
      .par        (din[i]),
      .q          (cells[i])
    );
  end

  assign q       = cells;
  assign msb_out = cells[MSB];
  assign lsb_out = cells[0];
endmodule

// File: rtl/usr_shift_chk.sv
module usr_shift_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] din,
  input logic             shr_in,
  input logic             shl_in,
  input logic [WIDTH-1:0] q,
  input logic             msb_out,
  input logic             lsb_out
);
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (q == '0)); // R1

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mode == 2'b00) |=> (q == $past(q))); // R2

  AST_SHR_MOVE: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mode == 2'b01) |=> (q == {$past(shr_in), $past(q[WIDTH-1:1])})); // R3

  AST_SHL_MOVE: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mode == 2'b10) |=> (q == {$past(q[WIDTH-2:0]), $past(shl_in)})); // R4

  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mode == 2'b11) |=> (q == $past(din))); // R5

  AST_SHR_ENDS: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mode == 2'b01) |=> (msb_out == $past(shr_in) && lsb_out == $past(q[1]))); // R6

  AST_SHL_ENDS: assert property (@(posedge clk) disable iff (!armed)
    (!clr && mode == 2'b10) |=> (lsb_out == $past(shl_in) && msb_out == $past(q[WIDTH-2]))); // R6
endmodule

bind usr_shift usr_shift_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .clr     (clr),
  .mode    (mode),
  .din     (din),
  .shr_in  (shr_in),
  .shl_in  (shl_in),
  .q       (q),
  .msb_out (msb_out),
  .lsb_out (lsb_out)
);

// File: tb/sim_usr_shift.sv
`timescale 1ns/1ps
module sim_usr_shift;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] din = '0;
  logic         shr_in = 1'b0;
  logic         shl_in = 1'b0;
  logic [W-1:0] q;
  logic         msb_out;
  logic         lsb_out;

  int tests = 0;
  int fails = 0;
  int model = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usr_shift #(.WIDTH(W)) u0 (
    .clk(clk), .clr(clr), .mode(mode), .din(din),
    .shr_in(shr_in), .shl_in(shl_in),
    .q(q), .msb_out(msb_out), .lsb_out(lsb_out)
  );

  function automatic string tag_of(input bit c, input int m);
    if (c) return "R1";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input bit c, input int m, input int d, input bit sr, input bit sl);
    string t;
    t = tag_of(c, m);
    clr = c; mode = m[1:0]; din = d[W-1:0]; shr_in = sr; shl_in = sl;
    @(posedge clk);
    if (c) model = 0;
    else if (m == 0) model = model;
    else if (m == 1) model = (model >> 1) | (int'(sr) << (W - 1));
    else if (m == 2) model = ((model << 1) | int'(sl)) & MASK;
    else model = d & MASK;
    @(negedge clk);
    tests++;
    if (int'(q) != model) begin
      fails++;
      $display("FAIL %s q: actual=%0h expected=%0h", t, q, model);
    end
    tests++;
    if (msb_out != model[W-1] || lsb_out != model[0]) begin
      fails++;
      $display("FAIL R6 ends (%s): actual=%b%b expected=%b%b", t,
               msb_out, lsb_out, model[W-1], model[0]);
    end
  endtask

  initial begin
    @(negedge clk);
    step(1, 3, 'hF, 1, 1);            // R1 reset state with load selected
    step(0, 3, 'hB, 0, 0);            // R5 load 1011
    step(0, 0, 'h4, 1, 1);            // R2 hold ignores din and serial ins
    step(0, 0, 'h0, 0, 0);            // R2
    step(0, 1, 'h0, 1, 0);            // R3 shift right, 1 enters at left
    step(0, 1, 'h0, 0, 1);            // R3 0 enters
    step(0, 1, 'h0, 1, 1);            // R3
    step(0, 2, 'h0, 0, 1);            // R4 shift left, 1 enters at right
    step(0, 2, 'h0, 1, 0);            // R4
    step(0, 3, 'h9, 0, 0);            // R5 load 1001
    step(1, 0, 'h0, 1, 1);            // R1 clear with hold
    step(0, 3, 'hF, 0, 0);            // R5
    step(1, 1, 'h0, 1, 1);            // R1 clear with shift right
    step(0, 3, 'hF, 0, 0);
    step(1, 2, 'h0, 1, 1);            // R1 clear with shift left
    for (int k = 0; k < W + 1; k++) step(0, 1, 0, 1, 0);  // R3 fill with ones
    for (int k = 0; k < W + 1; k++) step(0, 2, 0, 1, 0);  // R4 flush with zeros
    for (int k = 0; k < 400; k++) begin
      step(($urandom() % 8) == 0, int'($urandom() % 4), int'($urandom() % 16),
           bit'($urandom() % 2), bit'($urandom() % 2));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule